// File: doc/BRIEF.md
# Sub-Pixel Edge Timing Generator

This block produces the horizontal clocks, the reset-gate pulse, the sample strobes and a data clock for an image-sensor readout. The pixel period is split into 48 equal slots, and a counter driven by a fast clock steps through them, one slot per clock. Every pulse edge is set by a register and may sit in any slot, including placements that wrap across the period boundary. It is not a divided clock with a fixed duty cycle.

Edge registers are written through a small write port into a shadow copy. A two-state commit machine moves that copy into the active set only at the start of a pixel period. The states are `ST_SETTLED`, where the active set matches the shadow, and `ST_PENDING`, where a write is waiting. A write moves `ST_SETTLED` to `ST_PENDING`. The slot-47 boundary commits the shadow and moves `ST_PENDING` back to `ST_SETTLED`. If a write lands on that same boundary, the state stays `ST_PENDING` so the new value commits one period later.

Alongside the timing, an 11-stage pipeline carries pixel data taken at the data-sample strobe. It presents each sample on the output 11 pixel periods later, at the programmed output phase.

Top module: `pixel_edge_timer`

## Requirements
- R1: `slot` counts 0,1,…,47 with one step per clock and returns from 47 to 0.
- R2: While `rst` is high, at each clock edge: `slot` clears to 0, the pipeline and `pix_out` clear to 0, and the edge set loads its defaults. The defaults are reset-gate 0→12, horizontal 0→24, reference strobe 24, data strobe 0, output phase 0 and data-clock phase 0.
- R3: For a pulse whose rise slot is below its fall slot, the output is high in slots rise through fall−1 and low in all other slots.
- R4: For a pulse whose rise slot is above its fall slot, the output is high from the rise slot through 47 and from 0 through fall−1.
- R5: For a pulse whose rise slot equals its fall slot, the output stays low.
- R6: `h2_out` is always the complement of `h1_out`.
- R7: `ref_stb` is high only in the slot equal to the reference-strobe register. `dat_stb` is high only in the slot equal to the data-strobe register.
- R8: Writes use these addresses: 0 reset-gate rise, 1 reset-gate fall, 2 horizontal rise, 3 horizontal fall, 4 reference strobe, 5 data strobe, 6 output phase, 7 data-clock phase. A written value of 48 to 63 is stored minus 48.
- R9: A write reaches the outputs only from slot 0 of the next period. A write taken at the clock that ends slot 47 waits one more period.
- R10: At the clock ending the data-strobe slot, `pix_in` enters the pipeline. At the clock ending the output-phase slot, `pix_out` loads the sample from 11 strobes back. With both phases at 0, a sample taken in period p is shown from slot 1 of period p+11.
- R11: `dclk_out` is high for 24 slots starting at the data-clock phase, wrapping modulo 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 6 | Slot value to write |
| pix_in | input | 10 | Pixel data to sample |
| slot | output | 6 | Current slot within the pixel period |
| rg_out | output | 1 | Reset-gate pulse |
| h1_out | output | 1 | Primary horizontal clock |
| h2_out | output | 1 | Complementary horizontal clock |
| ref_stb | output | 1 | Reference-level sample strobe |
| dat_stb | output | 1 | Data-level sample strobe |
| dclk_out | output | 1 | Output data clock |
| pix_out | output | 10 | Delayed pixel data |

## Verification
The pulse and strobe outputs are combinational functions of `slot` and the active set. They are due in the same cycle as the slot, so every output is compared at the falling edge against a bench model stepped at each rising edge. A write is due one full boundary later: it must show from slot 0 of the next period, or one period after that when it lands on the slot-47 boundary. The checks sample inside the old period and then the new one to confirm this. `pix_out` is due 11 strobes after capture and is checked at slot 5 of periods 11 to 13 after reset.

// File: rtl/pet_pkg.sv
package pet_pkg;

    localparam int SLOTS      = 48;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int HALF_SLOTS = SLOTS / 2;
    localparam int ADDR_W     = 3;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [ADDR_W-1:0] {
        A_RG_RISE  = 3'd0,
        A_RG_FALL  = 3'd1,
        A_H_RISE   = 3'd2,
        A_H_FALL   = 3'd3,
        A_REF_SLOT = 3'd4,
        A_DAT_SLOT = 3'd5,
        A_OUT_PH   = 3'd6,
        A_DCLK_PH  = 3'd7
    } reg_addr_e;

    typedef enum logic [0:0] {
        ST_SETTLED = 1'b0,
        ST_PENDING = 1'b1
    } commit_st_e;

    typedef struct packed {
        slot_t rg_rise;
        slot_t rg_fall;
        slot_t h_rise;
        slot_t h_fall;
        slot_t ref_slot;
        slot_t dat_slot;
        slot_t out_ph;
        slot_t dclk_ph;
    } edge_set_t;

    localparam edge_set_t EDGE_DEFAULTS = '{
        rg_rise:  slot_t'(0),
        rg_fall:  slot_t'(12),
        h_rise:   slot_t'(0),
        h_fall:   slot_t'(24),
        ref_slot: slot_t'(24),
        dat_slot: slot_t'(0),
        out_ph:   slot_t'(0),
        dclk_ph:  slot_t'(0)
    };

    // Reduce a raw slot value into 0..SLOTS-1 (raw values are below 2*SLOTS).
    function automatic slot_t fold_slot(input logic [SLOT_W:0] raw);
        logic [SLOT_W:0] lim;
        lim = (SLOT_W+1)'(SLOTS);
        if (raw >= lim) return slot_t'(raw - lim);
        return slot_t'(raw);
    endfunction

endpackage

// File: rtl/pet_slot_counter.sv
module pet_slot_counter
    import pet_pkg::*;
#(
    parameter int N_SLOTS = SLOTS
) (
    input  logic  clk,
    input  logic  rst,
    output slot_t slot
);
    localparam slot_t LAST = slot_t'(N_SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)               slot <= '0;
        else if (slot == LAST) slot <= '0;
        else                   slot <= slot + 1'b1;
    end
endmodule

// File: rtl/pet_edge_regs.sv
module pet_edge_regs
    import pet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  slot_t             wr_data,
    input  slot_t             slot,
    output edge_set_t         active
);
    localparam slot_t LAST = slot_t'(SLOTS - 1);

    commit_st_e st_q;
    commit_st_e st_d;
    edge_set_t  shadow_q;
    slot_t      wval;
    logic       boundary;

    assign boundary = (slot == LAST);
    assign wval     = fold_slot({1'b0, wr_data});

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_SETTLED;
        else     st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SETTLED: if (wr_en) st_d = ST_PENDING;
            ST_PENDING: if (boundary && !wr_en) st_d = ST_SETTLED;
        endcase
    end

    // Shadow and active sets
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= EDGE_DEFAULTS;
            active   <= EDGE_DEFAULTS;
        end else begin
            if (st_q == ST_PENDING && boundary) active <= shadow_q;
            if (wr_en) begin
                unique case (reg_addr_e'(wr_addr))
                    A_RG_RISE:  shadow_q.rg_rise  <= wval;
                    A_RG_FALL:  shadow_q.rg_fall  <= wval;
                    A_H_RISE:   shadow_q.h_rise   <= wval;
                    A_H_FALL:   shadow_q.h_fall   <= wval;
                    A_REF_SLOT: shadow_q.ref_slot <= wval;
                    A_DAT_SLOT: shadow_q.dat_slot <= wval;
                    A_OUT_PH:   shadow_q.out_ph   <= wval;
                    A_DCLK_PH:  shadow_q.dclk_ph  <= wval;
                endcase
            end
        end
    end
endmodule

// File: rtl/pet_window.sv
module pet_window
    import pet_pkg::*;
(
    input  slot_t slot,
    input  slot_t rise,
    input  slot_t fall,
    output logic  level
);
    always_comb begin
        if (rise < fall)      level = (slot >= rise) && (slot < fall);
        else if (rise > fall) level = (slot >= rise) || (slot < fall);
        else                  level = 1'b0;
    end
endmodule

// File: rtl/pet_pipeline.sv
module pet_pipeline #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else if (load_en) dout <= stg[DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else if (shift_en) stg[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else if (shift_en) stg[i] <= stg[i-1];
        end
    end
endmodule

// File: rtl/pixel_edge_timer.sv
module pixel_edge_timer
    import pet_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int PIPE_DEPTH = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic [DATA_W-1:0] pix_in,
    output logic [SLOT_W-1:0] slot,
    output logic              rg_out,
    output logic              h1_out,
    output logic              h2_out,
    output logic              ref_stb,
    output logic              dat_stb,
    output logic              dclk_out,
    output logic [DATA_W-1:0] pix_out
);
    localparam int NWIN = 3;   // reset gate, horizontal, data clock
    localparam int W_RG = 0;
    localparam int W_H  = 1;
    localparam int W_DC = 2;

    edge_set_t act_edges;
    slot_t     dclk_fall;
    slot_t     rise_a [NWIN];
    slot_t     fall_a [NWIN];
    logic      lvl    [NWIN];

    pet_slot_counter #(.N_SLOTS(SLOTS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    pet_edge_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .slot    (slot),
        .active  (act_edges)
    );

    assign dclk_fall = fold_slot({1'b0, act_edges.dclk_ph} + (SLOT_W+1)'(HALF_SLOTS));

    assign rise_a[W_RG] = act_edges.rg_rise;
    assign fall_a[W_RG] = act_edges.rg_fall;
    assign rise_a[W_H]  = act_edges.h_rise;
    assign fall_a[W_H]  = act_edges.h_fall;
    assign rise_a[W_DC] = act_edges.dclk_ph;
    assign fall_a[W_DC] = dclk_fall;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        pet_window u_win (
            .slot  (slot),
            .rise  (rise_a[w]),
            .fall  (fall_a[w]),
            .level (lvl[w])
        );
    end

    assign rg_out   = lvl[W_RG];
    assign h1_out   = lvl[W_H];
    assign h2_out   = ~lvl[W_H];
    assign dclk_out = lvl[W_DC];
    assign ref_stb  = (slot == act_edges.ref_slot);
    assign dat_stb  = (slot == act_edges.dat_slot);

    pet_pipeline #(.DATA_W(DATA_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .shift_en (dat_stb),
        .load_en  (slot == act_edges.out_ph),
        .din      (pix_in),
        .dout     (pix_out)
    );
endmodule

// File: rtl/pet_checker.sv
module pet_checker
    import pet_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst,
    input slot_t             slot,
    input logic              rg_out,
    input logic              h1_out,
    input logic              h2_out,
    input logic              ref_stb,
    input logic              dat_stb,
    input logic [DATA_W-1:0] pix_out,
    input edge_set_t         act
);
    localparam slot_t LAST = slot_t'(SLOTS - 1);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot <= LAST);                                                    // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST) |=> (slot == slot_t'($past(slot) + 1'b1)));        // R1
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST) |=> (slot == '0));                                 // R1
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (slot == '0 && pix_out == '0));                    // R2
    AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (rst)
        (act.rg_rise == act.rg_fall) |-> !rg_out);                        // R5
    AST_H_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        h2_out == !h1_out);                                               // R6
    AST_REF_AT_SLOT: assert property (@(posedge clk) disable iff (rst)
        ref_stb |-> (slot == act.ref_slot));                              // R7
    AST_DAT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dat_stb |=> !dat_stb);                                            // R7
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (slot != '0) |-> $stable(act));                                   // R9
endmodule

bind pixel_edge_timer pet_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .slot    (slot),
    .rg_out  (rg_out),
    .h1_out  (h1_out),
    .h2_out  (h2_out),
    .ref_stb (ref_stb),
    .dat_stb (dat_stb),
    .pix_out (pix_out),
    .act     (act_edges)
);

// File: tb/pixel_edge_timer_tb_top.sv
module pixel_edge_timer_tb_top;
    localparam int DW = 10;
    localparam int PD = 11;
    localparam int NS = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [5:0]    wr_data = '0;
    logic [DW-1:0] pix_in = '0;
    logic [5:0]    slot;
    logic          rg_out, h1_out, h2_out, ref_stb, dat_stb, dclk_out;
    logic [DW-1:0] pix_out;

    always #4 clk = ~clk;   // 125 MHz

    pixel_edge_timer #(.DATA_W(DW), .PIPE_DEPTH(PD)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_in(pix_in), .slot(slot), .rg_out(rg_out), .h1_out(h1_out),
        .h2_out(h2_out), .ref_stb(ref_stb), .dat_stb(dat_stb),
        .dclk_out(dclk_out), .pix_out(pix_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit auto_on = 1'b0;
    bit done = 1'b0;

    // Reference model state (index map follows R8)
    int m_slot;
    int m_sh  [8];
    int m_act [8];
    int m_pipe[PD];
    int m_out;

    function automatic int dflt(input int i);
        case (i)
            1: return 12;
            3: return 24;
            4: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic int win(input int s, input int r, input int f);
        if (r < f) return int'(s >= r && s < f);
        if (r > f) return int'(s >= r || s < f);
        return 0;
    endfunction

    function automatic string wtag(input int r, input int f);
        if (r < f) return "R3";
        if (r > f) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, slot, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        int os;
        if (rst) begin
            m_slot = 0;
            m_out  = 0;
            for (int i = 0; i < 8; i++) begin m_sh[i] = dflt(i); m_act[i] = dflt(i); end
            for (int i = 0; i < PD; i++) m_pipe[i] = 0;
        end else begin
            os = m_slot;
            if (os == m_act[6]) m_out = m_pipe[PD-1];
            if (os == m_act[5]) begin
                for (int i = PD-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
                m_pipe[0] = int'(pix_in);
            end
            if (os == NS-1) for (int i = 0; i < 8; i++) m_act[i] = m_sh[i];
            if (wr_en) m_sh[wr_addr] = (int'(wr_data) >= NS) ? int'(wr_data) - NS : int'(wr_data);
            m_slot = (os + 1) % NS;
        end
    end

    always @(negedge clk) begin
        if (auto_on && !rst) begin
            check("R1", int'(slot), m_slot);
            check(wtag(m_act[0], m_act[1]), int'(rg_out), win(m_slot, m_act[0], m_act[1]));
            check(wtag(m_act[2], m_act[3]), int'(h1_out), win(m_slot, m_act[2], m_act[3]));
            check("R6", int'(h2_out), 1 - win(m_slot, m_act[2], m_act[3]));
            check("R7", int'(ref_stb), int'(m_slot == m_act[4]));
            check("R7", int'(dat_stb), int'(m_slot == m_act[5]));
            check("R11", int'(dclk_out), win(m_slot, m_act[7], (m_act[7] + NS/2) % NS));
            check("R10", int'(pix_out), m_out);
        end
    end

    task automatic wait_slot(input int s);
        while (int'(slot) != s) @(negedge clk);
    endtask

    task automatic write_reg(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 6'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R2: reset state seen at the release edge
        check("R2", int'(slot), 0);
        check("R2", int'(rg_out), 1);
        check("R2", int'(h1_out), 1);
        check("R2", int'(ref_stb), 0);
        check("R2", int'(dat_stb), 1);
        check("R2", int'(dclk_out), 1);
        check("R2", int'(pix_out), 0);
        auto_on = 1'b1;

        // R10: default phases, latency of 11 periods
        for (int cyc = 0; cyc < NS*14; cyc++) begin
            pix_in = DW'(100 + cyc / NS);
            if (cyc % NS == 5 && cyc / NS >= PD)
                check("R10", int'(pix_out), 100 + cyc / NS - PD);
            @(negedge clk);
        end

        // R8 fold + R9 deferral: horizontal fall written as 60 (-> 12) at slot 10
        wait_slot(10);
        write_reg(3, 60);
        wait_slot(15);
        check("R9", int'(h1_out), 1);
        @(negedge clk);
        wait_slot(15);
        check("R8", int'(h1_out), 0);

        // R9: write on the slot-47 boundary waits one extra period
        wait_slot(47);
        write_reg(1, 30);
        wait_slot(20);
        check("R9", int'(rg_out), 0);
        @(negedge clk);
        wait_slot(20);
        check("R9", int'(rg_out), 1);

        // R5: equal edges, R4: wrapped window
        wait_slot(2);
        write_reg(0, 20);
        write_reg(1, 20);
        repeat (NS) @(negedge clk);
        wait_slot(20);
        check("R5", int'(rg_out), 0);
        write_reg(0, 40);
        write_reg(1, 8);
        repeat (NS) @(negedge clk);
        wait_slot(3);
        check("R4", int'(rg_out), 1);
        wait_slot(44);
        check("R4", int'(rg_out), 1);

        // Random writes and data (model-checked every cycle)
        for (int cyc = 0; cyc < NS*40; cyc++) begin
            pix_in = DW'($urandom);
            if ($urandom % 12 == 0) begin
                wr_en = 1'b1; wr_addr = 3'($urandom); wr_data = 6'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        repeat (NS) @(negedge clk);
        finish_run();
    end
endmodule